// File: doc/BRIEF.md
# Reference Switch Phase-Step Absorber

This block sits between a reference clock selector and a digital PLL. All phase is measured in system-clock counts and kept modulo one frame period. Each reference frame pulse starts a down-counter loaded with the current build-out delay. When that counter runs out, the block emits a virtual reference pulse, and the PLL tracks this pulse instead of the raw reference. A local phase counter follows the old reference and runs free while a switch is being handled.

When the selector moves to a new source, it strobes a switch event. The block then asks the PLL to hold over and measures where the first pulse of the new reference lands against the free-running local phase. It subtracts that error from the build-out delay, so the virtual reference keeps the old phase. The PLL is released on the next feedback pulse. The delay builds up over successive switches. A qualified low level on the clear input walks the delay back to zero, moving it by a bounded amount per frame and in the shorter direction around the frame. A reference that stays silent for one and a half frames is flagged as missing.

Top module: `phase_step_absorber`

## Requirements
- R1: While reset is held, delay_val is 0 and vref_pulse, holdover and ref_missing are 0.
- R2: A ref_pulse sampled at clock edge E with delay D (0 ≤ D < FRAME_CNT) produces a one-cycle vref_pulse, high in the cycle after edge E+D. A later ref_pulse sampled before that pulse reloads the counter and cancels the pending pulse.
- R3: switch_evt sampled high raises holdover in the next cycle. The first ref_pulse after it is the measuring pulse.
- R4: At the measuring pulse, the new delay is (D_old − e) mod FRAME_CNT, where e is the number of edges since the last accepted ref_pulse, taken mod FRAME_CNT. The delay persists and builds up over successive switches, and delay_val is always below FRAME_CNT.
- R5: holdover falls in the cycle after the first fb_pulse sampled after the measuring pulse. An fb_pulse sampled before the measuring pulse leaves holdover high.
- R6: A clear is accepted only when clr_n is sampled low on CLR_MIN consecutive edges. A shorter low pulse leaves delay_val unchanged.
- R7: After an accepted clear, each ref_pulse outside the measuring phase moves the delay toward 0 by at most STEP_MAX counts. The measuring pulse applies no step. Stepping stops once the delay reaches 0.
- R8: Direction of a step: a delay D with 2·D ≤ FRAME_CNT decreases. A larger D increases and wraps to 0 once FRAME_CNT−D ≤ STEP_MAX.
- R9: ref_missing is high from the cycle after the (FRAME_CNT+FRAME_CNT/2)-th edge with no ref_pulse, and low in the cycle after any sampled ref_pulse.
- R10: A clear accepted on the same edge as switch_evt has both effects: holdover rises, the measuring pulse sets the new delay, and the walk to 0 starts from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one count of phase |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | Frame pulse of the selected reference, one cycle wide |
| fb_pulse | input | 1 | Frame pulse fed back from the PLL output |
| switch_evt | input | 1 | One-cycle strobe: the selected reference has changed |
| clr_n | input | 1 | Active-low request to zero the build-out delay |
| vref_pulse | output | 1 | Delayed virtual reference pulse to the PLL |
| delay_val | output | $clog2(FRAME_CNT) | Current build-out delay in clock counts |
| holdover | output | 1 | Request to the PLL to hold over |
| ref_missing | output | 1 | No reference pulse for 1.5 frames |

## Verification
The critical overlap is a clear being accepted on the same edge as a switch strobe. A clear-qualifying change and a measurement each want to rewrite the delay. The bench holds clr_n low and raises switch_evt exactly on the sixth low sample. It then shifts the new reference by 12 counts. The bench passes the case only if holdover rises and the measuring pulse sets 52 counts with no slew applied. After that, each following frame must step 56, 60 and then 0, and every virtual pulse must land at the cycle predicted from those values.

// File: rtl/asb_pkg.sv
package asb_pkg;

  typedef enum logic [1:0] {
    ST_TRACK   = 2'd0,
    ST_MEASURE = 2'd1,
    ST_APPLY   = 2'd2
  } asb_state_e;

  // Edges elapsed since the old reference slot, given the local phase
  // sampled on the edge that sees the new reference.
  function automatic int slot_error(input int loc, input int frame);
    return (loc + 1 >= frame) ? 0 : loc + 1;
  endfunction

  // Delay that keeps the virtual reference on the old phase.
  function automatic int delay_after_switch(input int d, input int e, input int frame);
    return (d >= e) ? d - e : d + frame - e;
  endfunction

  // One slew-limited move of the delay toward zero, shorter way round.
  function automatic int slew_toward_zero(input int d, input int step, input int frame);
    int rem;
    if (d == 0) return 0;
    if (2 * d <= frame) return (d > step) ? d - step : 0;
    rem = frame - d;
    return (rem > step) ? d + step : 0;
  endfunction

  // Distance between two phases on the frame circle.
  function automatic int circ_dist(input int a, input int b, input int frame);
    int diff;
    diff = (a >= b) ? a - b : b - a;
    return (frame - diff < diff) ? frame - diff : diff;
  endfunction

endpackage

// File: rtl/asb_clr_qual.sv
module asb_clr_qual #(
  parameter int CLR_MIN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  output logic clr_fire
);
  localparam int CW = $clog2(CLR_MIN + 1);

  logic [CW-1:0] low_cnt;

  assign clr_fire = !clr_n && (low_cnt == CW'(CLR_MIN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                          low_cnt <= '0;
    else if (clr_n)                      low_cnt <= '0;
    else if (low_cnt != CW'(CLR_MIN))    low_cnt <= low_cnt + 1'b1;
  end
endmodule

// File: rtl/asb_phase_track.sv
module asb_phase_track #(
  parameter int FRAME    = 2500,
  parameter int MISS_LIM = 3750
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ref_pulse,
  input  logic                      phase_resync,
  output logic [$clog2(FRAME)-1:0]  loc_phase,
  output logic                      ref_missing
);
  localparam int PW = $clog2(FRAME);
  localparam int MW = $clog2(MISS_LIM + 1);

  logic [MW-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                           loc_phase <= '0;
    else if (phase_resync)                loc_phase <= '0;
    else if (loc_phase == PW'(FRAME - 1)) loc_phase <= '0;
    else                                  loc_phase <= loc_phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              quiet_cnt <= '0;
    else if (ref_pulse)                      quiet_cnt <= '0;
    else if (quiet_cnt != MW'(MISS_LIM))     quiet_cnt <= quiet_cnt + 1'b1;
  end

  assign ref_missing = (quiet_cnt == MW'(MISS_LIM));
endmodule

// File: rtl/asb_delay_line.sv
module asb_delay_line #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_pulse,
  input  logic [PW-1:0] load_val,
  output logic          vref_pulse
);
  logic          armed;
  logic [PW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      remain <= '0;
    end else if (ref_pulse) begin
      armed  <= 1'b1;
      remain <= load_val;
    end else if (armed) begin
      if (remain == '0) armed  <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  assign vref_pulse = armed && (remain == '0);
endmodule

// File: rtl/asb_ctrl.sv
module asb_ctrl
  import asb_pkg::*;
#(
  parameter int FRAME = 2500,
  parameter int STEP  = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ref_pulse,
  input  logic                      fb_pulse,
  input  logic                      switch_evt,
  input  logic                      clr_fire,
  input  logic [$clog2(FRAME)-1:0]  loc_phase,
  output logic [$clog2(FRAME)-1:0]  delay_q,
  output logic [$clog2(FRAME)-1:0]  delay_next,
  output logic                      holdover,
  output logic                      meas_evt,
  output logic                      step_evt,
  output logic                      phase_resync
);
  localparam int PW = $clog2(FRAME);

  asb_state_e    st;
  logic          realign;
  logic [PW-1:0] d_meas;
  logic [PW-1:0] d_slew;
  int            err;

  always_comb begin
    err    = slot_error(int'(loc_phase), FRAME);
    d_meas = PW'(delay_after_switch(int'(delay_q), err, FRAME));
    d_slew = PW'(slew_toward_zero(int'(delay_q), STEP, FRAME));
  end

  assign meas_evt     = (st == ST_MEASURE) && ref_pulse && !switch_evt;
  assign step_evt     = ref_pulse && realign && (st != ST_MEASURE);
  assign phase_resync = ref_pulse && ((st != ST_MEASURE) || meas_evt);
  assign holdover     = (st != ST_TRACK);

  always_comb begin
    if (meas_evt)      delay_next = d_meas;
    else if (step_evt) delay_next = d_slew;
    else               delay_next = delay_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_TRACK;
    end else if (switch_evt) begin
      st <= ST_MEASURE;
    end else begin
      unique case (st)
        ST_MEASURE: if (meas_evt) st <= ST_APPLY;
        ST_APPLY:   if (fb_pulse) st <= ST_TRACK;
        default:    st <= st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delay_q <= '0;
      realign <= 1'b0;
    end else begin
      delay_q <= delay_next;
      if (clr_fire)                          realign <= 1'b1;
      else if (step_evt && d_slew == '0)     realign <= 1'b0;
    end
  end
endmodule

// File: rtl/phase_step_absorber.sv
module phase_step_absorber #(
  parameter int FRAME_CNT = 2500,
  parameter int STEP_MAX  = 1,
  parameter int CLR_MIN   = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ref_pulse,
  input  logic                          fb_pulse,
  input  logic                          switch_evt,
  input  logic                          clr_n,
  output logic                          vref_pulse,
  output logic [$clog2(FRAME_CNT)-1:0]  delay_val,
  output logic                          holdover,
  output logic                          ref_missing
);
  localparam int PW       = $clog2(FRAME_CNT);
  localparam int MISS_LIM = FRAME_CNT + FRAME_CNT / 2;

  // internal events, visible to the bound checker
  logic          clr_fire;
  logic          meas_evt;
  logic          step_evt;
  logic          phase_resync;
  logic [PW-1:0] loc_phase;
  logic [PW-1:0] delay_next;

  asb_clr_qual #(.CLR_MIN(CLR_MIN)) u_clr (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .clr_fire(clr_fire)
  );

  asb_phase_track #(.FRAME(FRAME_CNT), .MISS_LIM(MISS_LIM)) u_track (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse),
    .phase_resync(phase_resync), .loc_phase(loc_phase),
    .ref_missing(ref_missing)
  );

  asb_ctrl #(.FRAME(FRAME_CNT), .STEP(STEP_MAX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .switch_evt(switch_evt), .clr_fire(clr_fire), .loc_phase(loc_phase),
    .delay_q(delay_val), .delay_next(delay_next), .holdover(holdover),
    .meas_evt(meas_evt), .step_evt(step_evt), .phase_resync(phase_resync)
  );

  asb_delay_line #(.PW(PW)) u_dline (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse),
    .load_val(delay_next), .vref_pulse(vref_pulse)
  );
endmodule

// File: rtl/asb_chk.sv
module asb_chk #(
  parameter int FRAME = 2500,
  parameter int STEP  = 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ref_pulse,
  input logic                      fb_pulse,
  input logic                      switch_evt,
  input logic                      clr_n,
  input logic                      holdover,
  input logic                      ref_missing,
  input logic [$clog2(FRAME)-1:0]  delay_val,
  input logic                      clr_fire,
  input logic                      meas_evt
);
  AST_HOLD_FROM_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdover) |-> $past(switch_evt)); // R3
  AST_MEAS_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    meas_evt |-> holdover); // R3
  AST_HOLD_EXIT_FB: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holdover) |-> $past(fb_pulse)); // R5
  AST_CLR_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |-> !clr_n); // R6
  AST_SLEW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_evt |=> asb_pkg::circ_dist(int'(delay_val), int'($past(delay_val)), FRAME) <= STEP); // R7
  AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_missing); // R9
  AST_DELAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(delay_val) < FRAME); // R4
endmodule

bind phase_step_absorber asb_chk #(.FRAME(FRAME_CNT), .STEP(STEP_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
  .switch_evt(switch_evt), .clr_n(clr_n), .holdover(holdover),
  .ref_missing(ref_missing), .delay_val(delay_val), .clr_fire(clr_fire),
  .meas_evt(meas_evt)
);

// File: tb/phase_step_absorber_tb.sv
module phase_step_absorber_tb;
  localparam int CLK_NS = 10;
  localparam int F      = 64;
  localparam int STEP   = 4;
  localparam int CLRW   = 6;
  localparam int MISS   = F + F / 2;
  localparam int PW     = $clog2(F);

  logic clk = 0, rst_n = 0, ref_p = 0, fb = 0, sw = 0, clr_n = 1;
  logic          vref, hold, missing;
  logic [PW-1:0] dly;

  phase_step_absorber #(.FRAME_CNT(F), .STEP_MAX(STEP), .CLR_MIN(CLRW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_p), .fb_pulse(fb),
    .switch_evt(sw), .clr_n(clr_n), .vref_pulse(vref), .delay_val(dly),
    .holdover(hold), .ref_missing(missing)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; int d; string tag; } exp_t;
  exp_t q[$];
  exp_t it;

  int total = 0, bad = 0;
  int m_dly = 0, m_lastE = 0;
  bit m_meas = 0, m_realign = 0, done = 0;

  task automatic chk(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && vref) begin
      if (q.size() == 0) chk("R2 unexpected vref", cyc, -1);
      else begin
        it = q.pop_front();
        chk("R2 vref cycle", cyc, it.at);
        chk(it.tag, int'(dly), it.d);
      end
    end
  end

  // driver: called at a negedge, drives a reference pulse and predicts it
  task automatic pulse_ref(string tag);
    int e_edge;
    e_edge = cyc + 1;
    ref_p  = 1;
    if (m_meas) begin
      m_dly  = (m_dly - ((e_edge - m_lastE) % F) + F) % F;
      m_meas = 0;
    end else if (m_realign) begin
      if (m_dly != 0) begin
        if (2 * m_dly <= F) m_dly = (m_dly > STEP) ? m_dly - STEP : 0;
        else                m_dly = (m_dly + STEP >= F) ? 0 : m_dly + STEP;
      end
      if (m_dly == 0) m_realign = 0;
    end
    if (q.size() > 0 && q[q.size()-1].at >= e_edge) void'(q.pop_back());
    q.push_back('{e_edge + m_dly, m_dly, tag});
    m_lastE = e_edge;
    @(negedge clk);
    ref_p = 0;
  endtask

  task automatic ref_at(int gap, string tag);
    while (cyc < m_lastE + gap - 1) @(negedge clk);
    pulse_ref(tag);
  endtask

  task automatic do_switch();
    sw = 1;
    @(negedge clk);
    sw = 0;
    m_meas = 1;
    chk("R3 holdover after switch", int'(hold), 1);
  endtask

  task automatic do_fb(int exp_hold);
    fb = 1;
    @(negedge clk);
    fb = 0;
    chk("R5 holdover after fb", int'(hold), exp_hold);
  endtask

  task automatic do_clear(int width);
    clr_n = 0;
    repeat (width) @(negedge clk);
    clr_n = 1;
    if (width >= CLRW) m_realign = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 delay", int'(dly), 0);
    chk("R1 vref", int'(vref), 0);
    chk("R1 holdover", int'(hold), 0);
    chk("R1 missing", int'(missing), 0);
    rst_n = 1;
    @(negedge clk);

    // steady tracking with zero delay
    pulse_ref("R2 delay zero");
    ref_at(F, "R2 delay zero");
    ref_at(F, "R2 delay zero");

    // first switch: new reference 10 counts late
    repeat (20) @(negedge clk);
    do_switch();
    do_fb(1);                          // R5: fb before measurement ignored
    ref_at(F + 10, "R4 first switch");
    chk("R4 delay after late switch", int'(dly), 54);
    chk("R5 holdover held until fb", int'(hold), 1);
    do_fb(0);
    ref_at(F, "R4 persists");
    ref_at(F, "R4 persists");

    // second switch: 20 counts early, builds on the stored delay
    repeat (10) @(negedge clk);
    do_switch();
    ref_at(F - 20, "R4 accumulate");
    chk("R4 accumulated delay", int'(dly), 10);
    do_fb(0);
    ref_at(F, "R4 persists");

    // short clear ignored
    repeat (5) @(negedge clk);
    do_clear(CLRW - 1);
    ref_at(F, "R6 short clear ignored");
    chk("R6 delay after short clear", int'(dly), 10);

    // qualified clear, downward walk
    do_clear(CLRW);
    ref_at(F, "R7 slew down");
    chk("R7 first step", int'(dly), 6);
    ref_at(F, "R7 slew down");
    ref_at(F, "R7 slew down");
    chk("R7 reached zero", int'(dly), 0);
    ref_at(F, "R7 stays zero");

    // delay past half frame walks upward
    repeat (8) @(negedge clk);
    do_switch();
    ref_at(F + 5, "R4 switch to 59");
    do_fb(0);
    do_clear(CLRW);
    ref_at(F, "R8 slew up");
    chk("R8 upward step", int'(dly), 63);
    ref_at(F, "R8 wrap to zero");
    chk("R8 wrapped to zero", int'(dly), 0);

    // R10: clear accepted on the switch edge
    repeat (6) @(negedge clk);
    clr_n = 0;
    repeat (CLRW - 1) @(negedge clk);
    sw = 1;
    @(negedge clk);
    sw = 0;
    clr_n = 1;
    m_meas = 1;
    m_realign = 1;
    chk("R10 holdover on collision", int'(hold), 1);
    ref_at(F + 12, "R10 measure no step");
    chk("R10 measured delay", int'(dly), 52);
    ref_at(F, "R10 step in apply");
    chk("R10 step during holdover", int'(dly), 56);
    do_fb(0);
    ref_at(F, "R10 slew");
    ref_at(F, "R10 slew to zero");
    chk("R10 final delay", int'(dly), 0);

    // R9: missing reference
    while (cyc < m_lastE + MISS - 1) @(negedge clk);
    chk("R9 not yet missing", int'(missing), 0);
    @(negedge clk);
    chk("R9 missing", int'(missing), 1);
    pulse_ref("R9 recovery");
    chk("R9 cleared by ref", int'(missing), 0);

    repeat (F) @(negedge clk);
    chk("R2 pending vref", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule